// File: doc/BRIEF.md
# Dual-Rail Precharge Gate Bank

This block is a bank of dual-rail precharge logic cells. Each logical bit travels as a pair of wires, a true rail and a false rail. Both rails low means the pair is in precharge and carries no value. The value true is the pair (true=1, false=0) and the value false is (0, 1). Both rails high is illegal. Every cell alternates between a precharge phase and an evaluation phase. In each evaluation phase exactly one output rail rises, so each evaluation costs one output transition whatever the data.

A build-time parameter picks one of three cell styles. The monotone style uses only AND and OR cells and lets an output rise as soon as enough inputs allow it (early propagation). The synchronised style looks at all four input rails. It evaluates only when both operands hold a value and drops back to precharge as soon as either operand leaves evaluation. The latching style keeps its output in a register. It updates that register only when every input is in evaluation or every input is in precharge, and it holds the register through any mixed condition. All lanes share one operation code and one output-negation control.

The output of each lane is registered, so it appears one clock after its inputs. The operand pairs are plain level signals with no valid/ready handshake: a rail pair carries its own valid state, and a gate cell has no way to apply back-pressure.

Top module: `drp_gate_bank`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, every output pair is precharge (0,0).
- R2: Rail pairs are written {true,false}: 00 is precharge, 10 is true, 01 is false, and 11 is never driven. No output pair ever has both rails high. Each output is registered, so the pair seen after clock edge n is computed from the inputs sampled at edge n.
- R3: In every style, when all four input rails of a lane are 0, that lane's output is precharge one clock later.
- R4: In every style, when both operands are valid, the output is one-hot and carries the operation of `op_sel`: 0 AND, 1 OR, 2 XOR, 3 pass operand A.
- R5: Monotone style, early propagation. An AND output reads false as soon as either false input rail is high, and an OR output reads true as soon as either true input rail is high, even while the other operand is still precharged. An XOR cell is built from two AND cells and one OR cell, so it evaluates only when both operands are valid.
- R6: Synchronised style: for AND, OR and XOR, the output is precharge whenever either operand is precharged.
- R7: Latching style: for AND, OR and XOR, when exactly one operand is valid, the output keeps its previous pair.
- R8: With `invert` high, the output rails are swapped, which gives NAND, NOR, XNOR, and an inverter for op 3. With op 3, operand B has no effect in any style.
- R9: Lanes are independent: each lane's output depends only on that lane's inputs and on the shared `op_sel` and `invert` controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 2 | Operation: 0 AND, 1 OR, 2 XOR, 3 pass A |
| invert | input | 1 | Swap output rails (negated gate) |
| a_t | input | LANES | Operand A true rails |
| a_f | input | LANES | Operand A false rails |
| b_t | input | LANES | Operand B true rails |
| b_f | input | LANES | Operand B false rails |
| y_t | output | LANES | Result true rails |
| y_f | output | LANES | Result false rails |

## Verification
Two things can fall in the same cycle: one operand reaching or leaving evaluation, and the other operand being in the opposite phase. That mixed cycle is where the three styles differ. The monotone cell may already evaluate, the synchronised cell must drop to precharge, and the latching cell must hold. The bench provokes this by staggering arrivals: operand A first, then both operands, then A withdrawn while B stays valid, then full precharge, for every operation, negation and value. All three styles see the same stimulus, and each is compared every clock against a behavioural reference that tracks the previously held pair.

// File: rtl/drp_pkg.sv
package drp_pkg;

  typedef enum logic [1:0] {
    STYLE_MONO = 2'd0,
    STYLE_SYNC = 2'd1,
    STYLE_HOLD = 2'd2
  } style_e;

  typedef enum logic [1:0] {
    OP_AND  = 2'd0,
    OP_OR   = 2'd1,
    OP_XOR  = 2'd2,
    OP_PASS = 2'd3
  } op_e;

  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  function automatic logic rail_valid(rail_t r);
    return r.t | r.f;
  endfunction

  function automatic rail_t rail_swap(rail_t r);
    return rail_t'({r.f, r.t});
  endfunction

endpackage

// File: rtl/drp_mono_and.sv
module drp_mono_and
  import drp_pkg::*;
(
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  // true needs both true rails; false fires on either false rail
  assign y.t = a.t & b.t;
  assign y.f = a.f | b.f;
endmodule

// File: rtl/drp_mono_or.sv
module drp_mono_or
  import drp_pkg::*;
(
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  // true fires on either true rail; false needs both false rails
  assign y.t = a.t | b.t;
  assign y.f = a.f & b.f;
endmodule

// File: rtl/drp_mono_xor.sv
module drp_mono_xor
  import drp_pkg::*;
(
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  rail_t a_and_nb;
  rail_t na_and_b;

  // xor = (a & ~b) | (~a & b); an inversion is only a rail swap
  drp_mono_and u_and_hi (.a(a),            .b(rail_swap(b)), .y(a_and_nb));
  drp_mono_and u_and_lo (.a(rail_swap(a)), .b(b),            .y(na_and_b));
  drp_mono_or  u_or     (.a(a_and_nb),     .b(na_and_b),     .y(y));
endmodule

// File: rtl/drp_sync_core.sv
module drp_sync_core
  import drp_pkg::*;
(
  input  op_e   op,
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  logic bit_v;

  always_comb begin
    unique case (op)
      OP_AND:  bit_v = a.t & b.t;
      OP_OR:   bit_v = a.t | b.t;
      default: bit_v = a.t ^ b.t;
    endcase
  end

  // evaluates only once both operands carry a value
  always_comb begin
    if (op == OP_PASS)
      y = a;
    else if (rail_valid(a) && rail_valid(b))
      y = rail_t'({bit_v, ~bit_v});
    else
      y = '0;
  end
endmodule

// File: rtl/drp_lane.sv
module drp_lane
  import drp_pkg::*;
#(
  parameter style_e STYLE = STYLE_HOLD
) (
  input  logic  clk,
  input  logic  rst_n,
  input  op_e   op,
  input  logic  invert,
  input  rail_t a,
  input  rail_t b,
  output rail_t y
);
  rail_t core;
  rail_t y_d;
  rail_t y_q;
  logic  a_ok;
  logic  b_ok;
  logic  all_idle;
  logic  keep;
  logic [1:0] y_bits;

  assign a_ok     = rail_valid(a);
  assign b_ok     = rail_valid(b);
  assign all_idle = !a_ok && !b_ok;

  generate
    if (STYLE == STYLE_MONO) begin : g_mono
      rail_t m_and;
      rail_t m_or;
      rail_t m_xor;
      drp_mono_and u_and (.a(a), .b(b), .y(m_and));
      drp_mono_or  u_or  (.a(a), .b(b), .y(m_or));
      drp_mono_xor u_xor (.a(a), .b(b), .y(m_xor));
      always_comb begin
        unique case (op)
          OP_AND:  core = m_and;
          OP_OR:   core = m_or;
          OP_XOR:  core = m_xor;
          default: core = a;
        endcase
      end
    end else begin : g_sync
      drp_sync_core u_core (.op(op), .a(a), .b(b), .y(core));
    end
  endgenerate

  // latching style: mixed operand phases keep the stored pair
  assign keep = (STYLE == STYLE_HOLD) && (op != OP_PASS)
                && !(a_ok && b_ok) && !all_idle;

  always_comb begin
    if (keep)
      y_d = y_q;
    else if (invert)
      y_d = rail_swap(core);
    else
      y_d = core;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end

  assign y      = y_q;
  assign y_bits = y_q;

  a_r2_legal_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(a.t && a.f));
  a_r2_legal_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(b.t && b.f));
  a_r2_out_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(y_bits));
  a_r3_idle_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    all_idle |=> (y_bits == 2'b00));
  a_r4_eval_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ok && b_ok) |=> ($countones(y_bits) == 1));

  generate
    if (STYLE == STYLE_MONO) begin : g_chk_mono
      a_r5_or_early_true: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OR && !invert && (a.t || b.t)) |=> y_bits[1]);
      a_r5_and_early_false: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_AND && !invert && (a.f || b.f)) |=> y_bits[0]);
    end else if (STYLE == STYLE_SYNC) begin : g_chk_sync
      a_r6_drop_on_any_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_PASS && !(a_ok && b_ok)) |=> (y_bits == 2'b00));
    end else begin : g_chk_hold
      a_r7_hold_on_mixed: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_PASS && (a_ok != b_ok)) |=> (y_bits == $past(y_bits)));
    end
  endgenerate
endmodule

// File: rtl/drp_gate_bank.sv
module drp_gate_bank
  import drp_pkg::*;
#(
  parameter int     LANES = 4,
  parameter style_e STYLE = STYLE_HOLD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_sel,
  input  logic             invert,
  input  logic [LANES-1:0] a_t,
  input  logic [LANES-1:0] a_f,
  input  logic [LANES-1:0] b_t,
  input  logic [LANES-1:0] b_f,
  output logic [LANES-1:0] y_t,
  output logic [LANES-1:0] y_f
);
  op_e op;
  assign op = op_e'(op_sel);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rail_t y_i;
    drp_lane #(.STYLE(STYLE)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .invert (invert),
      .a      (rail_t'({a_t[i], a_f[i]})),
      .b      (rail_t'({b_t[i], b_f[i]})),
      .y      (y_i)
    );
    assign y_t[i] = y_i.t;
    assign y_f[i] = y_i.f;
  end
endmodule

// File: tb/tb_drp_gate_bank.sv
module tb_drp_gate_bank;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_sel = 2'd0;
  logic invert = 1'b0;
  logic [LANES-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic [LANES-1:0] yt_hold, yf_hold, yt_sync, yf_sync, yt_mono, yf_mono;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  string cur_tag = "R1";
  logic [1:0] mdl [3][LANES];

  always #5 clk = ~clk;

  drp_gate_bank #(.LANES(LANES), .STYLE(drp_pkg::STYLE_HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .invert(invert),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(yt_hold), .y_f(yf_hold));
  drp_gate_bank #(.LANES(LANES), .STYLE(drp_pkg::STYLE_SYNC)) dut_sync (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .invert(invert),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(yt_sync), .y_f(yf_sync));
  drp_gate_bank #(.LANES(LANES), .STYLE(drp_pkg::STYLE_MONO)) dut_mono (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .invert(invert),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .y_t(yt_mono), .y_f(yf_mono));

  // reference: sty 0 monotone, 1 synchronised, 2 latching; pairs are {t,f}
  function automatic logic [1:0] ref_next(int sty, int op, bit neg,
                                          logic [1:0] a, logic [1:0] b,
                                          logic [1:0] prev);
    bit av = (a != 2'b00);
    bit bv = (b != 2'b00);
    bit x = (a == 2'b10);
    bit z = (b == 2'b10);
    bit v;
    logic [1:0] r;
    if (op == 3) r = a;
    else if (sty == 0 && op == 0) r = {a[1] & b[1], a[0] | b[0]};
    else if (sty == 0 && op == 1) r = {a[1] | b[1], a[0] & b[0]};
    else if (av && bv) begin
      v = (op == 0) ? (x & z) : (op == 1) ? (x | z) : (x ^ z);
      r = {v, !v};
    end
    else if (sty == 2 && (av || bv)) return prev;
    else r = 2'b00;
    if (neg) r = {r[0], r[1]};
    return r;
  endfunction

  function automatic logic [1:0] dut_y(int s, int l);
    case (s)
      0: return {yt_mono[l], yf_mono[l]};
      1: return {yt_sync[l], yf_sync[l]};
      default: return {yt_hold[l], yf_hold[l]};
    endcase
  endfunction

  always @(posedge clk) begin
    for (int s = 0; s < 3; s++)
      for (int l = 0; l < LANES; l++)
        mdl[s][l] <= !rst_n ? 2'b00 :
          ref_next(s, int'(op_sel), invert, {a_t[l], a_f[l]}, {b_t[l], b_f[l]}, mdl[s][l]);
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #3;
    if (!finished) begin
      for (int s = 0; s < 3; s++)
        for (int l = 0; l < LANES; l++) begin
          checks++;
          if (dut_y(s, l) !== mdl[s][l]) begin
            errors++;
            $display("FAIL %s style=%0d lane=%0d op=%0d inv=%0b got=%b expected=%b",
                     cur_tag, s, l, op_sel, invert, dut_y(s, l), mdl[s][l]);
          end
        end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog (R1 to R9 incomplete) got=%0d cycles expected<=20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [1:0] enc(int bitval);
    return bitval[0] ? 2'b10 : 2'b01;
  endfunction

  // lane l pair sits at bits [2l+1:2l] as {t,f}
  task automatic drive(input logic [2*LANES-1:0] av, input logic [2*LANES-1:0] bv);
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      if (av[2*l +: 2] == 2'b11 || bv[2*l +: 2] == 2'b11) begin
        errors++;
        $display("FAIL R2 illegal pair lane=%0d got=%b/%b expected no 11",
                 l, av[2*l +: 2], bv[2*l +: 2]);
        a_t[l] = 1'b0; a_f[l] = 1'b0; b_t[l] = 1'b0; b_f[l] = 1'b0;
      end else begin
        a_t[l] = av[2*l+1]; a_f[l] = av[2*l];
        b_t[l] = bv[2*l+1]; b_f[l] = bv[2*l];
      end
    end
  endtask

  function automatic logic [2*LANES-1:0] pack_a(int c);
    logic [2*LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[2*l +: 2] = enc(((c + l) % 4) >> 1);
    return r;
  endfunction

  function automatic logic [2*LANES-1:0] pack_b(int c);
    logic [2*LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[2*l +: 2] = enc((c + l) % 4);
    return r;
  endfunction

  initial begin
    cur_tag = "R1 reset";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1 after reset";
    drive('0, '0);

    // all four combinations per lane, every operation and negation
    for (int op = 0; op < 4; op++)
      for (int ng = 0; ng < 2; ng++)
        for (int c = 0; c < 4; c++) begin
          op_sel = 2'(op); invert = ng[0];
          cur_tag = "R3 precharge";
          drive('0, '0);
          cur_tag = "R2 R4 R8 R9 evaluate";
          drive(pack_a(c), pack_b(c));
        end

    // staggered arrival and departure
    for (int op = 0; op < 4; op++)
      for (int ng = 0; ng < 2; ng++)
        for (int c = 0; c < 4; c++) begin
          op_sel = 2'(op); invert = ng[0];
          cur_tag = "R3 precharge";
          drive('0, '0);
          cur_tag = "R5 R6 R7 R8 A first";
          drive(pack_a(c), '0);
          cur_tag = "R4 both valid";
          drive(pack_a(c), pack_b(c));
          cur_tag = "R5 R6 R7 R8 A withdrawn";
          drive('0, pack_b(c));
          cur_tag = "R3 back to precharge";
          drive('0, '0);
        end

    // reset in the middle of evaluation
    op_sel = 2'd2; invert = 1'b0;
    cur_tag = "R4 before reset";
    drive(pack_a(1), pack_b(1));
    cur_tag = "R1 reset mid-evaluation";
    rst_n = 1'b0;
    drive(pack_a(1), '0);
    drive(pack_a(1), '0);
    rst_n = 1'b1;
    cur_tag = "R7 mixed after reset";
    drive(pack_a(1), '0);
    cur_tag = "R3 final precharge";
    drive('0, '0);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule